// File: doc/BRIEF.md
# JTAG Scan Chain Selector

This block is a four-bit test data register that decides which scan chain is placed between the test data input and the test data output. A "select chain" instruction is decoded elsewhere and presented as a flag. While that flag is set, the TAP state strobes drive the register. A capture loads a fixed marker pattern. A shift moves the old contents out, least significant bit first, while a new chain number moves in from TDI. An update copies the shifted value into a separate active-chain register. The active-chain register holds its value until the next update under the select instruction, or until a reset.

The active chain number is brought out on a four-bit port so that outside logic can decode it. When the select instruction is not current, the block routes the return data of the active chain to TDO:
- Four internal chains each have their own serial return input.
- Chain 3 and every unassigned number share one external serial path. TDI is always forwarded to that path.
- The two reserved numbers fall onto a one-bit pass stage, so that TDO always has a defined value.

TDO is launched on the falling edge of TCK. All register state moves on the rising edge.

Top module: `chain_sel_top`

## Requirements
- R1: An active-low reset `trstN` makes `activeChain` equal 3 and `extSel` equal 1, and clears `tdo` to 0.
- R2: A capture while `selInstr` is high loads binary 1000 into the select register. The four following shift cycles then present the bits 0, 0, 0, 1 on `tdo`, in that order.
- R3: Bits shifted in from `tdi` enter least significant bit first. An update while `selInstr` is high makes `activeChain` equal the four bits just shifted in.
- R4: When `selInstr` is low, capture, shift and update leave `activeChain` unchanged.
- R5: Capture and shift under `selInstr` that are not followed by an update leave `activeChain` unchanged.
- R6: `extSel` is 1 when `activeChain` is 3, 5, 6, 7, 9, 10, 11, 12, 13 or 14. It is 0 when `activeChain` is 0, 1, 2, 4, 8 or 15.
- R7: While `selInstr` is high, `tdo` shows bit 0 of the select register. Otherwise `tdo` follows the active chain:
  - chains 0, 1, 2 and 15 return `intRet[0]`, `intRet[1]`, `intRet[2]` and `intRet[3]` respectively;
  - external-path chains return `extRet`;
  - chains 4 and 8 return a one-bit stage that a capture clears to 0 and a shift loads from `tdi`.
- R8: `tdo` changes only on the falling edge of `tck`. A rising edge leaves it unchanged.
- R9: An update that follows a capture with no shift cycle in between selects chain 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous reset, active low |
| tdi | input | 1 | Serial test data in |
| captureDr | input | 1 | TAP is in the data-register capture state |
| shiftDr | input | 1 | TAP is in the data-register shift state |
| updateDr | input | 1 | TAP is in the data-register update state |
| selInstr | input | 1 | The chain-select instruction is current |
| intRet | input | 4 | Serial returns of internal chains 0, 1, 2 and 15 |
| extRet | input | 1 | Serial return of the external path |
| tdo | output | 1 | Serial test data out, launched on the falling edge |
| activeChain | output | 4 | Number of the active scan chain |
| extTdi | output | 1 | TDI forwarded to the external path |
| extSel | output | 1 | The external path is the active chain |

## Verification
A corrupted select register shows up on `tdo` during the next selection scan, within four falling edges after the capture. The marker bits come out in the wrong order or with the wrong value. A corrupted active-chain register shows up at once on `activeChain` and `extSel`. It also shows up one falling edge later as TDO data taken from the wrong return. To catch that case, the bench raises only the return of the expected chain, so any other choice reads back 0. A disturbance caused by shifting or by a stray strobe persists until the next valid update, so a single read after each stimulus exposes it.

// File: rtl/chain_sel_pkg.sv
package chain_sel_pkg;
  localparam int CHAIN_W = 4;
  localparam int NUM_INT = 4;
  localparam int NUM_BYP = 2;
  localparam logic [CHAIN_W-1:0] CAP_PATTERN = 4'b1000;
  localparam logic [CHAIN_W-1:0] RESET_CHAIN = 4'd3;
  // chain numbers served by internal return inputs, index = intRet bit
  localparam logic [CHAIN_W-1:0] INT_IDS [NUM_INT] = '{4'd0, 4'd1, 4'd2, 4'd15};
  // reserved chain numbers served by the one-bit pass stage
  localparam logic [CHAIN_W-1:0] BYP_IDS [NUM_BYP] = '{4'd4, 4'd8};

  typedef struct packed {
    logic capture;
    logic shift;
    logic update;
  } drStrobe_t;

  typedef enum logic [1:0] {
    SRC_INT = 2'd0,
    SRC_BYP = 2'd1,
    SRC_EXT = 2'd2
  } srcKind_t;
endpackage

// File: rtl/chain_sel_ctrl.sv
module chain_sel_ctrl
  import chain_sel_pkg::*;
(
  input  logic      captureDr,
  input  logic      shiftDr,
  input  logic      updateDr,
  input  logic      selInstr,
  output drStrobe_t selStb,
  output drStrobe_t dataStb
);
  // selection register strobes only under the select instruction
  always_comb begin
    selStb.capture  = captureDr & selInstr;
    selStb.shift    = shiftDr   & selInstr;
    selStb.update   = updateDr  & selInstr;
    dataStb.capture = captureDr & ~selInstr;
    dataStb.shift   = shiftDr   & ~selInstr;
    dataStb.update  = updateDr  & ~selInstr;
  end
endmodule

// File: rtl/chain_route.sv
module chain_route
  import chain_sel_pkg::*;
#(
  parameter int SEL_W = CHAIN_W,
  parameter int N_INT = NUM_INT,
  parameter int N_BYP = NUM_BYP,
  parameter int IDX_W = (N_INT > 1) ? $clog2(N_INT) : 1
) (
  input  logic [SEL_W-1:0] activeChain,
  output srcKind_t         kind,
  output logic [IDX_W-1:0] intIdx,
  output logic             extSel
);
  logic [N_INT-1:0] intHit;
  logic [N_BYP-1:0] bypHit;

  for (genvar g = 0; g < N_INT; g++) begin : g_int
    assign intHit[g] = (activeChain == INT_IDS[g]);
  end
  for (genvar g = 0; g < N_BYP; g++) begin : g_byp
    assign bypHit[g] = (activeChain == BYP_IDS[g]);
  end

  always_comb begin
    kind   = SRC_EXT;
    intIdx = '0;
    for (int i = 0; i < N_INT; i++) begin
      if (intHit[i]) begin
        kind   = SRC_INT;
        intIdx = IDX_W'(i);
      end
    end
    if (|bypHit) kind = SRC_BYP;
  end

  assign extSel = (kind == SRC_EXT);
endmodule

// File: rtl/chain_sel_dp.sv
module chain_sel_dp
  import chain_sel_pkg::*;
#(
  parameter int SEL_W = CHAIN_W,
  parameter int N_INT = NUM_INT,
  parameter int IDX_W = (N_INT > 1) ? $clog2(N_INT) : 1,
  parameter logic [SEL_W-1:0] CAP_VAL = CAP_PATTERN,
  parameter logic [SEL_W-1:0] RST_VAL = RESET_CHAIN
) (
  input  logic             tck,
  input  logic             trstN,
  input  logic             tdi,
  input  logic             selInstr,
  input  drStrobe_t        selStb,
  input  drStrobe_t        dataStb,
  input  logic [N_INT-1:0] intRet,
  input  logic             extRet,
  input  srcKind_t         kind,
  input  logic [IDX_W-1:0] intIdx,
  output logic [SEL_W-1:0] activeChain,
  output logic             tdo
);
  logic [SEL_W-1:0] shiftReg;
  logic [SEL_W-1:0] activeReg;
  logic             bypassReg;
  logic             tdoNext;

  // selection shift register: capture marker, shift lsb first
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)              shiftReg <= CAP_VAL;
    else if (selStb.capture) shiftReg <= CAP_VAL;
    else if (selStb.shift)   shiftReg <= {tdi, shiftReg[SEL_W-1:1]};
  end

  // active selection, separate from the shifting stage
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)             activeReg <= RST_VAL;
    else if (selStb.update) activeReg <= shiftReg;
  end

  // one-bit pass stage for reserved numbers
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)               bypassReg <= 1'b0;
    else if (dataStb.capture) bypassReg <= 1'b0;
    else if (dataStb.shift)   bypassReg <= tdi;
  end

  always_comb begin
    if (selInstr) tdoNext = shiftReg[0];
    else begin
      unique case (kind)
        SRC_INT: tdoNext = intRet[intIdx];
        SRC_BYP: tdoNext = bypassReg;
        default: tdoNext = extRet;
      endcase
    end
  end

  // launch on the falling edge
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) tdo <= 1'b0;
    else        tdo <= tdoNext;
  end

  assign activeChain = activeReg;

  // R2
  cap_load_chk: assert property (@(posedge tck) disable iff (!trstN)
    selStb.capture |=> shiftReg == CAP_VAL);
  // R3
  shift_lsb_chk: assert property (@(posedge tck) disable iff (!trstN)
    selStb.shift |=> shiftReg[SEL_W-2:0] == $past(shiftReg[SEL_W-1:1]));
  // R3
  update_copy_chk: assert property (@(posedge tck) disable iff (!trstN)
    selStb.update |=> activeReg == $past(shiftReg));
  // R4
  active_hold_chk: assert property (@(posedge tck) disable iff (!trstN)
    !selStb.update |=> $stable(activeReg));
  // R7
  byp_clear_chk: assert property (@(posedge tck) disable iff (!trstN)
    dataStb.capture |=> !bypassReg);
  // R7
  sel_tdo_chk: assert property (@(negedge tck) disable iff (!trstN)
    selInstr |=> tdo == $past(shiftReg[0]));
endmodule

// File: rtl/chain_sel_top.sv
module chain_sel_top
  import chain_sel_pkg::*;
#(
  parameter int SEL_W = CHAIN_W,
  parameter int N_INT = NUM_INT,
  parameter int N_BYP = NUM_BYP
) (
  input  logic             tck,
  input  logic             trstN,
  input  logic             tdi,
  input  logic             captureDr,
  input  logic             shiftDr,
  input  logic             updateDr,
  input  logic             selInstr,
  input  logic [N_INT-1:0] intRet,
  input  logic             extRet,
  output logic             tdo,
  output logic [SEL_W-1:0] activeChain,
  output logic             extTdi,
  output logic             extSel
);
  localparam int IDX_W = (N_INT > 1) ? $clog2(N_INT) : 1;

  drStrobe_t        selStb;
  drStrobe_t        dataStb;
  srcKind_t         kind;
  logic [IDX_W-1:0] intIdx;

  chain_sel_ctrl ctrl_i (
    .captureDr(captureDr), .shiftDr(shiftDr), .updateDr(updateDr),
    .selInstr(selInstr), .selStb(selStb), .dataStb(dataStb)
  );

  chain_route #(.SEL_W(SEL_W), .N_INT(N_INT), .N_BYP(N_BYP), .IDX_W(IDX_W)) route_i (
    .activeChain(activeChain), .kind(kind), .intIdx(intIdx), .extSel(extSel)
  );

  chain_sel_dp #(.SEL_W(SEL_W), .N_INT(N_INT), .IDX_W(IDX_W)) dp_i (
    .tck(tck), .trstN(trstN), .tdi(tdi), .selInstr(selInstr),
    .selStb(selStb), .dataStb(dataStb), .intRet(intRet), .extRet(extRet),
    .kind(kind), .intIdx(intIdx), .activeChain(activeChain), .tdo(tdo)
  );

  assign extTdi = tdi;

  // R6
  reset_chain_ext_chk: assert property (@(posedge tck) disable iff (!trstN)
    (activeChain == RESET_CHAIN) |-> extSel);
endmodule

// File: tb/chain_sel_top_tb.sv
module chain_sel_top_tb_top;
  localparam int TCK_PERIOD = 10;
  localparam int NVEC = 12;
  // {chain[3:0], expExt, expKind[1:0] (0 int,1 pass,2 ext), intIndex[1:0]}
  localparam logic [8:0] VEC [NVEC] = '{
    {4'd0,  1'b0, 2'd0, 2'd0}, {4'd1,  1'b0, 2'd0, 2'd1},
    {4'd2,  1'b0, 2'd0, 2'd2}, {4'd15, 1'b0, 2'd0, 2'd3},
    {4'd4,  1'b0, 2'd1, 2'd0}, {4'd8,  1'b0, 2'd1, 2'd0},
    {4'd3,  1'b1, 2'd2, 2'd0}, {4'd5,  1'b1, 2'd2, 2'd0},
    {4'd9,  1'b1, 2'd2, 2'd0}, {4'd14, 1'b1, 2'd2, 2'd0},
    {4'd7,  1'b1, 2'd2, 2'd0}, {4'd12, 1'b1, 2'd2, 2'd0}
  };

  logic tck = 1'b0;
  logic trstN = 1'b0;
  logic tdi = 1'b0, captureDr = 1'b0, shiftDr = 1'b0, updateDr = 1'b0, selInstr = 1'b0;
  logic [3:0] intRet = '0;
  logic extRet = 1'b0;
  logic tdo, extTdi, extSel;
  logic [3:0] activeChain;
  int nRun = 0, nFail = 0;
  bit finished = 0;

  always #(TCK_PERIOD/2) tck = ~tck;

  chain_sel_top dut_i (
    .tck(tck), .trstN(trstN), .tdi(tdi), .captureDr(captureDr), .shiftDr(shiftDr),
    .updateDr(updateDr), .selInstr(selInstr), .intRet(intRet), .extRet(extRet),
    .tdo(tdo), .activeChain(activeChain), .extTdi(extTdi), .extSel(extSel)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic scanDr(input logic sel, input logic [3:0] v, input int nBits,
                        input logic upd, output logic [3:0] so);
    so = '0;
    @(negedge tck); #1;
    selInstr = sel; captureDr = 1; shiftDr = 0; updateDr = 0;
    @(posedge tck);
    for (int i = 0; i < nBits; i++) begin
      @(negedge tck); #1;
      captureDr = 0; shiftDr = 1; tdi = v[i]; so[i] = tdo;
      @(posedge tck); #1;
      check(tdo === so[i], "R8", tdo, so[i]);
    end
    @(negedge tck); #1;
    captureDr = 0; shiftDr = 0; updateDr = upd;
    @(posedge tck);
    @(negedge tck); #1;
    updateDr = 0;
  endtask

  initial begin
    #(TCK_PERIOD * 20000);
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    logic [3:0] so;
    repeat (3) @(negedge tck);
    #1;
    // R1 reset state
    check(activeChain === 4'd3, "R1", activeChain, 3);
    check(extSel === 1'b1, "R1", extSel, 1);
    check(tdo === 1'b0, "R1", tdo, 0);
    trstN = 1;

    for (int k = 0; k < NVEC; k++) begin
      logic [3:0] ch;
      logic expExt;
      logic [1:0] kindE, idx;
      {ch, expExt, kindE, idx} = VEC[k];
      scanDr(1'b1, ch, 4, 1'b1, so);
      // R2 R7 marker shifted out lsb first
      check(so === 4'b1000, "R2", so, 8);
      check(activeChain === ch, "R3", activeChain, ch);
      check(extSel === expExt, "R6", extSel, expExt);
      // R7 data scan on the active chain
      @(negedge tck); #1;
      selInstr = 0; captureDr = 1; tdi = 0; intRet = '0; extRet = 0;
      @(posedge tck);
      @(negedge tck); #1;
      check(tdo === 1'b0, "R7", tdo, 0);
      captureDr = 0; shiftDr = 1;
      tdi = (kindE == 2'd1);
      intRet = (kindE == 2'd0) ? (4'b0001 << idx) : 4'b0000;
      extRet = (kindE == 2'd2);
      @(posedge tck);
      @(negedge tck); #1;
      check(tdo === 1'b1, "R7", tdo, 1);
      shiftDr = 0; tdi = 0; intRet = '0; extRet = 0;
    end

    // R4 full scan without the select instruction
    scanDr(1'b0, 4'd0, 4, 1'b1, so);
    check(activeChain === 4'd12, "R4", activeChain, 12);
    check(extSel === 1'b1, "R4", extSel, 1);
    // R5 shift under select without update
    scanDr(1'b1, 4'd1, 4, 1'b0, so);
    check(activeChain === 4'd12, "R5", activeChain, 12);
    // R9 capture then update, no shift
    scanDr(1'b1, 4'd0, 0, 1'b1, so);
    check(activeChain === 4'd8, "R9", activeChain, 8);
    check(extSel === 1'b0, "R9", extSel, 0);
    // R1 reset in the middle of operation
    @(negedge tck); #1;
    trstN = 0;
    #2;
    check(activeChain === 4'd3, "R1", activeChain, 3);
    check(extSel === 1'b1, "R1", extSel, 1);
    check(tdo === 1'b0, "R1", tdo, 0);
    @(negedge tck); #1;
    trstN = 1;
    // R3 selection after reset
    scanDr(1'b1, 4'd2, 4, 1'b1, so);
    check(so === 4'b1000, "R2", so, 8);
    check(activeChain === 4'd2, "R3", activeChain, 2);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule